// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write Lock

This block is a synthesizable model of a small serial EEPROM that sits as a slave on a two-wire bus. The system clock oversamples the bus clock and data lines. The block finds START and STOP conditions and shifts in bytes on rising bus-clock edges. It also drives the data line only by pulling it low, through an open-drain pull-down enable. The array is a register bank of `DEPTH` bytes. Its contents appear on a flat output, so the surrounding logic or a bench can see them directly.

A transfer opens with a device-select byte. The upper nibble must carry the fixed type code, and the next three bits must match the strap pins. A write follows the select byte with a one-byte word address and then any number of data bytes. A read returns bytes from the current word address for as long as the master acknowledges. A random read is done with a write select, an address byte, a repeated START and a read select.

The write-lock input protects the whole array. While it is high, the select and address bytes are still acknowledged, but every data byte of a write is refused with NACK and is not stored.

Top module: `eeprom_tw_slave`

## Requirements
- R1: After reset, `sda_pull` is 0 and every byte of `mem_o` is 0. The block never drives the data line high: a 1 on `sda_pull` means pull low, and a 0 means release.
- R2: A falling data line while the bus clock is high (START) starts reception of a select byte. A rising data line while the clock is high (STOP) returns the block to idle with the line released. Either condition works at any bit position, including in the middle of a byte.
- R3: The select byte is sent MSB first. Bits 7..4 must equal 1010, and bits 3, 2 and 1 must equal `sel_pins[2]`, `sel_pins[1]` and `sel_pins[0]`. Bit 0 is the direction, with 1 meaning read. A match is acknowledged by pulling the line low in the ninth clock. A mismatch gets no acknowledge, and the following bytes are ignored until the next START.
- R4: The byte after a write select is the word address. It is acknowledged, and its low log2(`DEPTH`) bits become the current address.
- R5: With `wr_lock` low, each data byte after the address is stored at the current address and acknowledged. The address then increments and wraps from `DEPTH-1` to 0. `DEPTH` is a power of two.
- R6: With `wr_lock` high, the select and address bytes are still acknowledged, but every write data byte is answered with NACK. No location of the array changes.
- R7: After an acknowledged read select, the byte at the current address is sent MSB first. Each bit is placed on the line after a falling bus-clock edge. The line is released for the master's acknowledge slot.
- R8: A master ACK during a read increments the current address (with wrap) and starts the next byte. A master NACK ends the read with the line released, and the address stays at the byte just sent.

Ports are described in the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Bus clock as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus (wired-AND level) |
| sel_pins | input | 3 | Strap pins for select bits 3..1; tie low when unused |
| wr_lock | input | 1 | High blocks every array write; tie low when unused |
| sda_pull | output | 1 | Open-drain pull-down enable for the data line |
| mem_o | output | DEPTH*8 | Array contents, byte k at bits [8k+7:8k] |

## Verification
The hardest state to reach from the pins is the read path that follows a random-access address. Reaching it takes a write select, an address byte, a repeated START without a STOP, and then a read select. The bench's bit-level master produces this exact sequence and runs it across the top of the array, so the address wrap is exercised in both the write and read directions. A STOP is also issued after only four select bits, to show that the byte engine recovers mid-byte. The locked case checks three things: both header bytes are still acknowledged, the data byte is refused, and the whole array is compared afterwards.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_e;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_ADDR,
    BK_DATA
  } kind_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign sda_lvl   = sda_s;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [7:0]        wdata,
  input  logic [AW-1:0]     raddr,
  output logic [7:0]        rdata,
  output logic [DEPTH*8-1:0] flat
);
  logic [7:0] word [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word[g] <= 8'h00;
      end else if (we && (waddr == AW'(g))) begin
        word[g] <= wdata;
      end
    end
    assign flat[g*8 +: 8] = word[g];
  end

  assign rdata = word[raddr];
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [2:0]    sel_pins,
  input  logic          wr_lock,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] rd_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          sda_pull
);
  phase_e        phase_q, phase_d;
  kind_e         kind_q, kind_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    shr_q, shr_d;
  logic [7:0]    tx_q, tx_d;
  logic [AW-1:0] addr_q, addr_d, addr_inc;
  logic          rw_q, rw_d;
  logic          mack_q, mack_d;
  logic          pull_q, pull_d;
  logic          dev_ok;

  assign addr_inc  = addr_q + AW'(1);
  assign dev_ok    = (shr_q[7:4] == TYPE_CODE) && (shr_q[3:1] == sel_pins);
  assign rd_addr   = (phase_q == PH_MACK) ? addr_inc : addr_q;
  assign mem_waddr = addr_q;
  assign mem_wdata = shr_q;
  assign sda_pull  = pull_q;

  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    shr_d   = shr_q;
    tx_d    = tx_q;
    addr_d  = addr_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    pull_d  = pull_q;
    mem_we  = 1'b0;
    if (start_det) begin
      phase_d = PH_RX;
      kind_d  = BK_DEV;
      cnt_d   = 4'd0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      pull_d  = 1'b0;
    end else begin
      case (phase_q)
        PH_RX: begin
          if (scl_rise && (cnt_q != 4'd8)) begin
            shr_d = {shr_q[6:0], sda_lvl};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && (cnt_q == 4'd8)) begin
            case (kind_q)
              BK_DEV: begin
                if (dev_ok) begin
                  pull_d  = 1'b1;
                  rw_d    = shr_q[0];
                  phase_d = PH_ACK;
                end else begin
                  phase_d = PH_IDLE;
                end
              end
              BK_ADDR: begin
                addr_d  = shr_q[AW-1:0];
                pull_d  = 1'b1;
                phase_d = PH_ACK;
              end
              default: begin
                if (wr_lock) begin
                  phase_d = PH_IDLE;
                end else begin
                  mem_we  = 1'b1;
                  addr_d  = addr_inc;
                  pull_d  = 1'b1;
                  phase_d = PH_ACK;
                end
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if ((kind_q == BK_DEV) && rw_q) begin
              tx_d    = rd_byte;
              pull_d  = ~rd_byte[7];
              phase_d = PH_TX;
            end else begin
              pull_d  = 1'b0;
              phase_d = PH_RX;
              kind_d  = (kind_q == BK_DEV) ? BK_ADDR : BK_DATA;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              pull_d  = 1'b0;
              phase_d = PH_MACK;
            end else begin
              tx_d   = {tx_q[6:0], 1'b0};
              pull_d = ~tx_q[6];
              cnt_d  = cnt_q + 4'd1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              addr_d  = addr_inc;
              tx_d    = rd_byte;
              pull_d  = ~rd_byte[7];
              cnt_d   = 4'd0;
              phase_d = PH_TX;
            end else begin
              phase_d = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= BK_DEV;
      cnt_q   <= 4'd0;
      shr_q   <= 8'h00;
      tx_q    <= 8'h00;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      shr_q   <= shr_d;
      tx_q    <= tx_d;
      addr_q  <= addr_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      pull_q  <= pull_d;
    end
  end
endmodule

// File: rtl/eeprom_tw_slave.sv
module eeprom_tw_slave #(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [2:0]         sel_pins,
  input  logic               wr_lock,
  output logic               sda_pull,
  output logic [DEPTH*8-1:0] mem_o
);
  logic [1:0]    rst_ff;
  logic          rst_ns;
  logic          scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, rd_addr;
  logic [7:0]    mem_wdata, rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff <= 2'b00;
    end else begin
      rst_ff <= {rst_ff[0], 1'b1};
    end
  end
  assign rst_ns = rst_ff[1];

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_ns), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .sel_pins(sel_pins), .wr_lock(wr_lock), .rd_byte(rd_byte),
    .rd_addr(rd_addr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .sda_pull(sda_pull)
  );

  eep_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_ns), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(rd_addr), .rdata(rd_byte), .flat(mem_o)
  );
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
  parameter int MEM_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_lock,
  input logic             sda_pull,
  input logic [MEM_W-1:0] mem_o,
  input logic             mem_we,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det
);
  assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  assert_lock_array_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |=> $stable(mem_o));

  assert_lock_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wr_lock);

  assert_write_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> scl_fall);

  assert_pull_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));
endmodule

bind eeprom_tw_slave eep_checker #(.MEM_W(DEPTH*8)) u_chk (
  .clk(clk), .rst_n(rst_ns), .wr_lock(wr_lock), .sda_pull(sda_pull),
  .mem_o(mem_o), .mem_we(mem_we), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det)
);

// File: tb/eeprom_tw_slave_bench.sv
module eeprom_tw_slave_bench;
  localparam int DEPTH = 16;
  localparam int Q     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] sel_pins = 3'b101;
  logic wr_lock = 1'b0;
  logic sda_pull;
  logic [DEPTH*8-1:0] mem_o;
  logic sda_line;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];

  assign sda_line = m_sda & ~sda_pull;

  always #2.5 clk = ~clk;

  eeprom_tw_slave #(.DEPTH(DEPTH)) u_eeprom_tw_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sel_pins(sel_pins), .wr_lock(wr_lock), .sda_pull(sda_pull), .mem_o(mem_o)
  );

  // lock, address, data
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'h05, 8'h3C},
    {1'b0, 8'h0A, 8'hC3},
    {1'b1, 8'h05, 8'hFF},
    {1'b0, 8'h1F, 8'h81},
    {1'b1, 8'h0A, 8'h00},
    {1'b0, 8'h00, 8'h7E}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DEPTH*8-1:0] model_flat();
    logic [DEPTH*8-1:0] f;
    for (int i = 0; i < DEPTH; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_start();
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic t_stop();
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(Q);
  endtask

  task automatic t_bit_out(input logic b);
    m_sda = b; hold(Q);
    m_scl = 1'b1; hold(2*Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic t_bit_in(output logic b);
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    b = sda_line; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic t_wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) t_bit_out(v[i]);
    t_bit_in(b);
    ack = ~b;
  endtask

  task automatic t_rbyte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      t_bit_in(b);
      v[i] = b;
    end
    t_bit_out(~mack);
  endtask

  function automatic logic [7:0] dsel(input logic [2:0] pins, input logic rd);
    return {4'b1010, pins, rd};
  endfunction

  initial begin
    logic ack, ack_a, ack_d;
    logic [7:0] rv;
    logic [3:0] a;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    hold(4);
    rst_n = 1'b1;
    hold(8);

    // R1: reset state
    chk(sda_pull == 1'b0, "R1 reset pull", 32'(sda_pull), 0);
    chk(mem_o == '0, "R1 reset array", 32'(mem_o != '0), 0);

    // table walk: write (maybe locked) then random read
    for (int v = 0; v < 6; v++) begin
      wr_lock = VEC[v][16];
      a = VEC[v][11:8];
      t_start();
      t_wbyte(dsel(sel_pins, 1'b0), ack);
      chk(ack == 1'b1, "R3 select ack", 32'(ack), 1);
      t_wbyte(VEC[v][15:8], ack_a);
      chk(ack_a == 1'b1, "R4 address ack", 32'(ack_a), 1);
      t_wbyte(VEC[v][7:0], ack_d);
      t_stop();
      if (!VEC[v][16]) model[a] = VEC[v][7:0];
      if (VEC[v][16]) chk(ack_d == 1'b0, "R6 locked data nack", 32'(ack_d), 0);
      else chk(ack_d == 1'b1, "R5 data ack", 32'(ack_d), 1);
      chk(mem_o == model_flat(), "R5 R6 array content", 32'(mem_o[a*8 +: 8]), 32'(model[a]));
      wr_lock = 1'b0;
      t_start();
      t_wbyte(dsel(sel_pins, 1'b0), ack);
      t_wbyte(VEC[v][15:8], ack);
      t_start();
      t_wbyte(dsel(sel_pins, 1'b1), ack);
      chk(ack == 1'b1, "R3 read select ack", 32'(ack), 1);
      t_rbyte(1'b0, rv);
      t_stop();
      chk(rv == model[a], "R7 random read data", 32'(rv), 32'(model[a]));
    end

    // R3: strap mismatch ignored, including the following bytes
    t_start();
    t_wbyte(dsel(3'b011, 1'b0), ack);
    chk(ack == 1'b0, "R3 pin mismatch nack", 32'(ack), 0);
    t_wbyte(8'h02, ack_a);
    t_wbyte(8'h99, ack_d);
    t_stop();
    chk(ack_a == 1'b0 && ack_d == 1'b0, "R3 bytes after mismatch ignored", 32'({ack_a, ack_d}), 0);
    chk(mem_o == model_flat(), "R3 array untouched", 32'(mem_o[2*8 +: 8]), 32'(model[2]));

    // R3: wrong type code
    t_start();
    t_wbyte({4'b1011, sel_pins, 1'b0}, ack);
    t_stop();
    chk(ack == 1'b0, "R3 wrong type nack", 32'(ack), 0);

    // R3: other strap value
    sel_pins = 3'b000;
    t_start();
    t_wbyte(8'hA0, ack);
    t_stop();
    chk(ack == 1'b1, "R3 zero straps ack", 32'(ack), 1);
    sel_pins = 3'b101;

    // R5: multi-byte write across the top of the array
    t_start();
    t_wbyte(dsel(sel_pins, 1'b0), ack);
    t_wbyte(8'h0E, ack);
    t_wbyte(8'h11, ack_d); chk(ack_d == 1'b1, "R5 burst ack 0", 32'(ack_d), 1);
    t_wbyte(8'h22, ack_d); chk(ack_d == 1'b1, "R5 burst ack 1", 32'(ack_d), 1);
    t_wbyte(8'h33, ack_d); chk(ack_d == 1'b1, "R5 burst ack wrap", 32'(ack_d), 1);
    t_stop();
    model[14] = 8'h11; model[15] = 8'h22; model[0] = 8'h33;
    chk(mem_o == model_flat(), "R5 wrap write", 32'(mem_o[7:0]), 32'h33);

    // R8: sequential read with wrap, ending on NACK
    t_start();
    t_wbyte(dsel(sel_pins, 1'b0), ack);
    t_wbyte(8'h0E, ack);
    t_start();
    t_wbyte(dsel(sel_pins, 1'b1), ack);
    t_rbyte(1'b1, rv); chk(rv == 8'h11, "R8 seq byte 0", 32'(rv), 32'h11);
    t_rbyte(1'b1, rv); chk(rv == 8'h22, "R8 seq byte 1", 32'(rv), 32'h22);
    t_rbyte(1'b0, rv); chk(rv == 8'h33, "R8 seq byte wrap", 32'(rv), 32'h33);
    chk(sda_pull == 1'b0, "R8 released after nack", 32'(sda_pull), 0);
    t_stop();

    // R7: current-address read stays on last byte after NACK
    t_start();
    t_wbyte(dsel(sel_pins, 1'b1), ack);
    t_rbyte(1'b0, rv);
    t_stop();
    chk(rv == 8'h33, "R7 current address read", 32'(rv), 32'h33);

    // R2: STOP in the middle of a byte, then a normal write
    t_start();
    for (int i = 7; i >= 4; i--) t_bit_out(dsel(sel_pins, 1'b0) >> i);
    t_stop();
    chk(sda_pull == 1'b0, "R2 idle after mid-byte stop", 32'(sda_pull), 0);
    t_start();
    t_wbyte(dsel(sel_pins, 1'b0), ack);
    chk(ack == 1'b1, "R2 recovery select ack", 32'(ack), 1);
    t_wbyte(8'h03, ack);
    t_wbyte(8'h5A, ack_d);
    t_stop();
    model[3] = 8'h5A;
    chk(mem_o == model_flat(), "R2 write after recovery", 32'(mem_o[3*8 +: 8]), 32'h5A);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule